// File: doc/BRIEF.md
# DMA Channel Host Register File

This block is the host-facing register file of a four-channel DMA controller whose host bus is only one byte wide. It holds, for every channel, a 16-bit starting address, a 16-bit starting count, an 8-bit page value that supplies the physical address bits above the 16-bit address, and a small mode register. It also holds a per-channel mask bit. The transfer engine that walks through memory is outside the block. The engine takes the stored values from the block's outputs, and it returns its running address and count so that the host can read them back.

All registers wider than a byte are reached through one byte port. A single byte-pointer flip-flop, shared by every channel, selects the low half or the high half. Each access to an address or count port flips the pointer. A dedicated command puts it back to the low state, so software issues that command once and then accesses the low byte before the high byte. There are also commands to set or clear all mask bits at once and to reset the register state from software.

Top module: `dma_host_regs`

## Requirements
- R1: After hardware reset the byte pointer is in the low state, all mask bits are 1, every mode register is 0, and the base address, base count and page registers are 0. The mask status port at 0x16 reads the mask bits in bits [3:0], with bit n for channel n, and reads 0 in the upper bits.
- R2: A write to port 0x00+n (address of channel n) or 0x04+n (count of channel n) stores the data byte in the low half of the 16-bit base register when the pointer is low, and in the high half when the pointer is high.
- R3: Every read or write of ports 0x00–0x07 toggles the byte pointer. An access to any other port leaves the pointer unchanged.
- R4: A write of any value to port 0x10 puts the byte pointer into the low state.
- R5: A read of port 0x00+n returns the running address input of channel n, and a read of port 0x04+n returns its running count input. The low byte is returned when the pointer is low and the high byte when it is high. A finished count of 0xFFFF reads back as 0xFF twice.
- R6: Port 0x08+n writes and reads the 8-bit page register of channel n, and the register appears on `page_o`.
- R7: A write to port 0x12 stores data bits [7:2] into the mode register of the channel named by data bits [1:0]. In those bits, [3:2] is the direction (01 peripheral-to-memory, 10 memory-to-peripheral), bit 4 enables auto-initialise, bit 5 selects a decrementing address, and [7:6] is the transfer type (01 single). Port 0x0C+n reads back {mode, n}.
- R8: A write to port 0x13 sets the mask bit of the channel in data bits [1:0] to the value of data bit 2. The other mask bits are unchanged.
- R9: A write to port 0x14 clears all mask bits. A write to port 0x15 sets all mask bits.
- R10: A write to port 0x16 is a software reset. It clears the byte pointer and the mode registers and sets all mask bits. Base, count and page registers keep their values.
- R11: In the cycle after each byte write to an address or count port, `addr_load_o` or `cnt_load_o` (whichever matches the port) pulses for exactly one cycle. The pulse is one-hot on the written channel and tells the engine to copy the base value into its running register.
- R12: `cascade_o[n]` is high when the transfer type field of channel n holds 11 (cascade pass-through).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Host access select |
| wr | input | 1 | Write strobe (wins over rd) |
| rd | input | 1 | Read strobe |
| addr | input | 5 | Port number |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational) |
| cur_addr_i | input | NCH*16 | Running address from engine, channel n at [16n+:16] |
| cur_cnt_i | input | NCH*16 | Running count from engine, channel n at [16n+:16] |
| base_addr_o | output | NCH*16 | Base address registers |
| base_cnt_o | output | NCH*16 | Base count registers |
| page_o | output | NCH*PW | Page registers |
| mode_o | output | NCH*6 | Mode registers (data bits [7:2]) |
| mask_o | output | NCH | Channel mask bits (1 = disabled) |
| cascade_o | output | NCH | Channel in cascade mode |
| addr_load_o | output | NCH | Load pulse for running address |
| cnt_load_o | output | NCH | Load pulse for running count |

## Verification
The assertions check the pointer on every cycle: it flips on each 16-bit port access, holds on every other cycle, and is low after the clear and soft-reset commands. They also check that the mask and mode state after a bulk mask command or a soft reset is correct, and that load pulses are one-hot and come only after a matching write. Only the bench scenarios can show that a byte reaches the right half of the right channel, and that readback returns the engine's bytes in low-then-high order. The bench also shows that reads of other ports do not disturb the pointer and that a soft reset leaves the base and page contents in place.

// File: rtl/dma_host_regs.sv
module dma_host_regs #(
  parameter int NCH = 4,
  parameter int PW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [4:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NCH*16-1:0] cur_addr_i,
  input  logic [NCH*16-1:0] cur_cnt_i,
  output logic [NCH*16-1:0] base_addr_o,
  output logic [NCH*16-1:0] base_cnt_o,
  output logic [NCH*PW-1:0] page_o,
  output logic [NCH*6-1:0]  mode_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    cascade_o,
  output logic [NCH-1:0]    addr_load_o,
  output logic [NCH-1:0]    cnt_load_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic        ptr;
  logic [15:0] ba [NCH];
  logic [15:0] bc [NCH];
  logic [PW-1:0] pg [NCH];
  logic [5:0]  md [NCH];

  wire          we    = cs & wr;
  wire          re    = cs & rd & ~wr;
  wire [2:0]    grp   = addr[4:2];
  wire [CW-1:0] ch    = addr[CW-1:0];
  wire [CW-1:0] dch   = wdata[CW-1:0];
  wire          in_ch = int'(addr[1:0]) < NCH;
  wire          acc16 = (we | re) & in_ch & (grp == 3'd0 || grp == 3'd1);

  wire cmd_clr  = we && addr == 5'h10;
  wire cmd_mode = we && addr == 5'h12;
  wire cmd_msk1 = we && addr == 5'h13;
  wire cmd_mclr = we && addr == 5'h14;
  wire cmd_mset = we && addr == 5'h15;
  wire cmd_srst = we && addr == 5'h16;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ptr <= 1'b0;
    else if (cmd_clr | cmd_srst) ptr <= 1'b0;
    else if (acc16)              ptr <= ~ptr;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      wire sel   = in_ch && ch == CW'(i);
      wire w_adr = we && sel && grp == 3'd0;
      wire w_cnt = we && sel && grp == 3'd1;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ba[i] <= '0;
          bc[i] <= '0;
          pg[i] <= '0;
          addr_load_o[i] <= 1'b0;
          cnt_load_o[i]  <= 1'b0;
        end else begin
          addr_load_o[i] <= w_adr;
          cnt_load_o[i]  <= w_cnt;
          if (w_adr) begin
            if (ptr) ba[i][15:8] <= wdata;
            else     ba[i][7:0]  <= wdata;
          end
          if (w_cnt) begin
            if (ptr) bc[i][15:8] <= wdata;
            else     bc[i][7:0]  <= wdata;
          end
          if (we && sel && grp == 3'd2) pg[i] <= wdata[PW-1:0];
        end

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                      md[i] <= '0;
        else if (cmd_srst)               md[i] <= '0;
        else if (cmd_mode && dch == CW'(i)) md[i] <= wdata[7:2];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                      mask_o[i] <= 1'b1;
        else if (cmd_srst || cmd_mset)   mask_o[i] <= 1'b1;
        else if (cmd_mclr)               mask_o[i] <= 1'b0;
        else if (cmd_msk1 && dch == CW'(i)) mask_o[i] <= wdata[2];

      assign base_addr_o[i*16 +: 16] = ba[i];
      assign base_cnt_o[i*16 +: 16]  = bc[i];
      assign page_o[i*PW +: PW]      = pg[i];
      assign mode_o[i*6 +: 6]        = md[i];
      assign cascade_o[i]            = md[i][5:4] == 2'b11;
    end
  endgenerate

  wire [15:0] cur_a = cur_addr_i[ch*16 +: 16];
  wire [15:0] cur_c = cur_cnt_i[ch*16 +: 16];

  always_comb begin
    rdata = 8'h00;
    if (addr == 5'h16)
      rdata = 8'(mask_o);
    else if (in_ch)
      case (grp)
        3'd0:    rdata = ptr ? cur_a[15:8] : cur_a[7:0];
        3'd1:    rdata = ptr ? cur_c[15:8] : cur_c[7:0];
        3'd2:    rdata = 8'(pg[ch]);
        3'd3:    rdata = {md[ch], 2'(ch)};
        default: rdata = 8'h00;
      endcase
  end

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc16 && !cmd_clr && !cmd_srst) |=> (ptr != $past(ptr)));
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc16 && !cmd_clr && !cmd_srst) |=> $stable(ptr));
  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !ptr);
  assert_srst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_srst |=> (&mask_o && mode_o == '0 && !ptr));
  assert_mset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mset |=> &mask_o);
  assert_mclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mclr |=> mask_o == '0);
  assert_load_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_load_o) && $onehot0(cnt_load_o) && !(|addr_load_o && |cnt_load_o));
  assert_load_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_load_o || |cnt_load_o) |-> $past(we && in_ch && grp[2:1] == 2'b00));
endmodule

// File: tb/tb_dma_host_regs.sv
module tb_dma_host_regs;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [NCH*16-1:0] cur_addr = 0, cur_cnt = 0;
  wire  [7:0] rdata;
  wire  [NCH*16-1:0] base_addr, base_cnt;
  wire  [NCH*8-1:0] page;
  wire  [NCH*6-1:0] mode;
  wire  [NCH-1:0] mask, cascade, aload, cload;

  dma_host_regs dut (.clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt),
    .base_addr_o(base_addr), .base_cnt_o(base_cnt), .page_o(page), .mode_o(mode),
    .mask_o(mask), .cascade_o(cascade), .addr_load_o(aload), .cnt_load_o(cload));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wreg(logic [4:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rexp(logic [4:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(int'(e)); tag_q.push_back(tag);
    cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  always @(negedge clk) begin
    #5;
    if (cs && rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #(20 * 100000);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mask after reset", 32'(mask), 32'hF);
    chk("R1 mode after reset", 32'(mode), 0);
    chk("R1 base addr after reset", 32'(base_addr[31:0]), 0);
    rst_n = 1;
    rexp(5'h16, 8'h0F, "R1 mask status read");

    wreg(5'h10, 8'h00);
    wreg(5'h01, 8'h34);
    chk("R11 addr load pulse ch1 low", 32'(aload), 32'h2);
    chk("R11 no count load", 32'(cload), 0);
    wreg(5'h01, 8'h12);
    chk("R11 addr load pulse ch1 high", 32'(aload), 32'h2);
    chk("R2 base addr ch1", 32'(base_addr[31:16]), 32'h1234);
    @(negedge clk);
    chk("R11 pulse lasts one cycle", 32'(aload), 0);
    wreg(5'h06, 8'hCD);
    wreg(5'h06, 8'hAB);
    chk("R2 base count ch2", 32'(base_cnt[47:32]), 32'hABCD);
    chk("R11 count load pulse ch2", 32'(cload), 32'h4);

    cur_addr[15:0]  = 16'hBEEF;
    cur_addr[31:16] = 16'h7A21;
    cur_cnt[47:32]  = 16'h1357;
    cur_cnt[63:48]  = 16'hFFFF;
    rexp(5'h01, 8'h21, "R5 addr ch1 low");
    rexp(5'h01, 8'h7A, "R5 addr ch1 high");
    rexp(5'h06, 8'h57, "R5 count ch2 low");
    rexp(5'h06, 8'h13, "R5 count ch2 high");
    rexp(5'h07, 8'hFF, "R5 finished count low");
    rexp(5'h07, 8'hFF, "R5 finished count high");

    wreg(5'h00, 8'h99);
    wreg(5'h10, 8'h00);
    rexp(5'h00, 8'hEF, "R4 clear pointer gives low byte");

    wreg(5'h08, 8'h5A);
    chk("R6 page_o ch0", 32'(page[7:0]), 32'h5A);
    rexp(5'h08, 8'h5A, "R6 page readback");
    rexp(5'h00, 8'hBE, "R3 page access kept pointer");
    rexp(5'h16, 8'h0F, "R3 status read");
    rexp(5'h00, 8'hEF, "R3 pointer toggled after high read");

    wreg(5'h12, 8'h56);
    chk("R7 mode ch2 field", 32'(mode[17:12]), 32'h15);
    rexp(5'h0E, 8'h56, "R7 mode ch2 readback");
    chk("R12 ch2 not cascade", 32'(cascade), 0);
    wreg(5'h12, 8'hC3);
    chk("R12 cascade ch3", 32'(cascade), 32'h8);
    rexp(5'h0F, 8'hC3, "R7 mode ch3 readback");

    wreg(5'h14, 8'h00);
    chk("R9 clear all masks", 32'(mask), 0);
    wreg(5'h13, 8'h05);
    chk("R8 set mask ch1", 32'(mask), 32'h2);
    wreg(5'h13, 8'h07);
    chk("R8 set mask ch3", 32'(mask), 32'hA);
    wreg(5'h13, 8'h01);
    chk("R8 clear mask ch1", 32'(mask), 32'h8);
    wreg(5'h15, 8'h00);
    chk("R9 set all masks", 32'(mask), 32'hF);

    wreg(5'h14, 8'h00);
    wreg(5'h12, 8'h59);
    wreg(5'h02, 8'h11);
    wreg(5'h16, 8'h00);
    chk("R10 masks set", 32'(mask), 32'hF);
    chk("R10 modes cleared", 32'(mode), 0);
    chk("R10 base addr kept", 32'(base_addr[31:16]), 32'h1234);
    chk("R10 page kept", 32'(page[7:0]), 32'h5A);
    rexp(5'h00, 8'hEF, "R10 pointer cleared");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule